// File: doc/BRIEF.md
# J1850 Frame CRC-8 Generator and Checker

This block computes the 8-bit frame check byte of a byte-oriented J1850-style link layer and checks it on receive. A frame opens with a start-of-frame strobe, which presets the remainder register to all ones. Message bytes then arrive on a valid/ready byte stream: the priority/type byte, the message ID byte, and any optional data bytes. Each byte is folded into the remainder most significant bit first, using the divisor x^8+x^4+x^3+x^2+1.

For transmit, the host reads `crc_out` once the last data byte has been absorbed and `in_ready` has returned high. It appends that byte to the frame, most significant bit first. `crc_out` is always the one's complement of the current remainder. For receive, the host feeds every byte after start-of-frame, including the received check byte, and then pulses `eod`. One cycle later, `chk_done` pulses for one cycle, together with the error flags for that frame.

The datapath handles `BITS_PER_STEP` bits per clock. At the default of 2, each byte takes four clocks, and `in_ready` stays low for the three clocks after a byte is taken. A byte is transferred on a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold `in_data` stable and keep `in_valid` high. `in_ready` is also low during any cycle in which `sof` is high.

Top module: `j1850_crc8_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `crc_out` is 0x00 (the complement of the 0xFF preset), and `chk_done`, `crc_err` and `len_err` are 0.
- R2: Each accepted byte updates the remainder with divisor 0x1D (x^8+x^4+x^3+x^2+1), processing bit 7 first. Whenever no byte is in flight, `crc_out` equals the bitwise complement of the remainder.
- R3: A `sof` pulse presets the remainder to 0xFF, so `crc_out` reads 0x00 on the following cycle.
- R4: When the bytes of a frame are followed by the `crc_out` value read after them, the receive check of that frame reports `crc_err` = 0.
- R5: On an honoured `eod`, `chk_done` is 1 for exactly the next cycle. In that cycle, `crc_err` is 1 if the remainder differs from the residue 0xC4. `crc_err` and `len_err` are never 1 without `chk_done`.
- R6: A frame with fewer than two accepted bytes at `eod` (no data byte before the check byte) reports `crc_err` = 1.
- R7: A `sof` arriving in the middle of a frame, or in the middle of a byte, abandons that work without raising any flag. The next frame is then computed from a fresh 0xFF preset.
- R8: `len_err` is 1 at `chk_done` when more than 12 bytes, counting the check byte, were accepted since `sof`. With 12 or fewer bytes it is 0.
- R9: After a byte is accepted, `in_ready` stays low for `8/BITS_PER_STEP - 1` cycles. A byte offered while `in_ready` is low is not consumed.
- R10: `eod` is honoured only when `in_ready` is 1. An `eod` during a byte in flight produces no `chk_done`.
- R11: A byte offered in the same cycle as `sof` is not accepted and does not enter the remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; presets and aborts |
| eod | input | 1 | End-of-data pulse; triggers the receive check |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte stream data |
| crc_out | output | 8 | Complement of the current remainder |
| chk_done | output | 1 | One-cycle pulse after an honoured `eod` |
| crc_err | output | 1 | Residue mismatch or missing data byte |
| len_err | output | 1 | Frame longer than the maximum |

## Verification
The assertions assume that `eod` never coincides with `in_valid`, because a byte and an end-of-data in the same cycle would make the outcome of the check ambiguous. They also assume that a stalled source keeps its byte stable. The stimulus raises `eod` only on cycles with `in_valid` low. It holds each byte until it is accepted, and it places `sof` pulses both between frames and in the middle of bytes. A deliberate `eod` during a busy byte is issued with `in_valid` low, so it stays within the assumption.

// File: rtl/j1850_crc_pkg.sv
package j1850_crc_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t CRC_POLY    = 8'h1D;
  localparam byte_t CRC_PRESET  = 8'hFF;
  localparam byte_t CRC_RESIDUE = 8'hC4;
endpackage

// File: rtl/j1850_crc_stepper.sv
module j1850_crc_stepper
  import j1850_crc_pkg::*;
#(
  parameter int W = 2
) (
  input  byte_t        rem_in,
  input  logic [W-1:0] bits,
  output byte_t        rem_out
);
  byte_t chain [W+1];
  assign chain[0] = rem_in;
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic fb;
    assign fb = chain[g][7] ^ bits[W-1-g];
    assign chain[g+1] = {chain[g][6:0], 1'b0} ^ ({8{fb}} & CRC_POLY);
  end
  assign rem_out = chain[W];
endmodule

// File: rtl/j1850_byte_feeder.sv
module j1850_byte_feeder
  import j1850_crc_pkg::*;
#(
  parameter int B = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         abort,
  input  logic         in_valid,
  input  byte_t        in_data,
  output logic         in_ready,
  output logic         accept,
  output logic         step_en,
  output logic [B-1:0] chunk
);
  localparam int STEPS = 8 / B;

  if (STEPS == 1) begin : g_full
    assign in_ready = !abort;
    assign accept   = in_valid && in_ready;
    assign step_en  = accept;
    assign chunk    = in_data;
  end else begin : g_part
    localparam int LW = $clog2(STEPS);
    logic [LW-1:0] left;
    byte_t         sh;
    logic          busy;
    assign busy     = (left != '0);
    assign in_ready = !busy && !abort;
    assign accept   = in_valid && in_ready;
    assign step_en  = (accept || busy) && !abort;
    assign chunk    = accept ? in_data[7 -: B] : sh[7 -: B];

    always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
        left <= '0;
        sh   <= '0;
      end else if (accept) begin
        left <= LW'(STEPS - 1);
        sh   <= in_data << B;
      end else if (busy) begin
        left <= left - 1'b1;
        sh   <= sh << B;
      end
    end
  end
endmodule

// File: rtl/j1850_len_counter.sv
module j1850_len_counter #(
  parameter int MAX_BYTES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic too_long,
  output logic too_short
);
  localparam int CW  = $clog2(MAX_BYTES + 2);
  localparam int SAT = MAX_BYTES + 1;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                 count <= '0;
    else if (inc && count != CW'(SAT))   count <= count + 1'b1;
  end

  assign too_long  = (count > CW'(MAX_BYTES));
  assign too_short = (count < CW'(2));
endmodule

// File: rtl/j1850_crc8_engine.sv
module j1850_crc8_engine
  import j1850_crc_pkg::*;
#(
  parameter int BITS_PER_STEP = 2,
  parameter int MAX_BYTES     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       eod,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic [7:0] crc_out,
  output logic       chk_done,
  output logic       crc_err,
  output logic       len_err
);
  logic                     accept, step_en;
  logic [BITS_PER_STEP-1:0] chunk;
  byte_t                    rem_q, rem_d;
  logic                     too_long, too_short;

  j1850_byte_feeder #(.B(BITS_PER_STEP)) i_feed (
    .clk(clk), .rst_n(rst_n), .abort(sof),
    .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .accept(accept),
    .step_en(step_en), .chunk(chunk)
  );

  j1850_crc_stepper #(.W(BITS_PER_STEP)) i_step (
    .rem_in(rem_q), .bits(chunk), .rem_out(rem_d)
  );

  j1850_len_counter #(.MAX_BYTES(MAX_BYTES)) i_len (
    .clk(clk), .rst_n(rst_n), .clear(sof), .inc(accept),
    .too_long(too_long), .too_short(too_short)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || sof) rem_q <= CRC_PRESET;
    else if (step_en)  rem_q <= rem_d;
  end

  logic eod_ok;
  assign eod_ok = eod && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      crc_err  <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      chk_done <= eod_ok;
      crc_err  <= eod_ok && (too_short || rem_q != CRC_RESIDUE);
      len_err  <= eod_ok && too_long;
    end
  end

  assign crc_out = ~rem_q;
endmodule

// File: rtl/j1850_crc8_checker.sv
module j1850_crc8_checker #(
  parameter int BITS_PER_STEP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       eod,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] crc_out,
  input logic       chk_done,
  input logic       crc_err,
  input logic       len_err
);
  if (BITS_PER_STEP < 8) begin : g_hs
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
  end

  p_sof_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (crc_out == 8'h00));

  p_sof_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !chk_done);

  p_flag_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err || len_err) |-> chk_done);

  p_done_from_eod_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $past(eod));

  p_eod_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eod |-> !in_valid);
endmodule

bind j1850_crc8_engine j1850_crc8_checker #(.BITS_PER_STEP(BITS_PER_STEP)) i_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .eod(eod), .in_valid(in_valid),
  .in_ready(in_ready), .crc_out(crc_out), .chk_done(chk_done),
  .crc_err(crc_err), .len_err(len_err)
);

// File: tb/test_j1850_crc8_engine.sv
module test_j1850_crc8_engine;
  localparam int BPS   = 2;
  localparam int STEPS = 8 / BPS;
  localparam int MAXB  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, eod = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, chk_done, crc_err, len_err;
  logic [7:0] crc_out;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int         m_rem = 8'hFF, m_cnt = 0, m_left = 0;
  logic       m_done = 0, m_cerr = 0, m_lerr = 0;

  always #10 clk = ~clk;

  j1850_crc8_engine #(.BITS_PER_STEP(BPS), .MAX_BYTES(MAXB)) i_j1850_crc8_engine (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eod(eod), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .crc_out(crc_out),
    .chk_done(chk_done), .crc_err(crc_err), .len_err(len_err)
  );

  function automatic int ref_byte(int r, logic [7:0] b);
    int x = r;
    for (int i = 7; i >= 0; i--) begin
      bit top = x[7] ^ b[i];
      x = (x << 1) & 8'hFF;
      if (top) x = x ^ 8'h1D;
    end
    return x;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic s,
                      input logic e, output bit acc);
    bit rdy;
    @(negedge clk);
    if (m_left == 0) chk("R2", crc_out, (~m_rem) & 8'hFF);
    chk("R5", chk_done, m_done);
    chk("R5", crc_err, m_cerr);
    chk("R8", len_err, m_lerr);
    in_valid = v; in_data = d; sof = s; eod = e;
    #1;
    rdy = (m_left == 0) && !s;
    chk("R9", in_ready, rdy);
    acc = v && rdy;
    m_done = e && rdy;
    m_cerr = m_done && (m_cnt < 2 || m_rem != 8'hC4);
    m_lerr = m_done && (m_cnt > MAXB);
    if (s) begin
      m_rem = 8'hFF; m_cnt = 0; m_left = 0;
    end else if (acc) begin
      m_rem = ref_byte(m_rem, d);
      if (m_cnt < MAXB + 1) m_cnt++;
      m_left = STEPS - 1;
    end else if (m_left > 0) m_left--;
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, a);
  endtask

  task automatic send(logic [7:0] d);
    bit a = 0;
    while (!a) step(1, d, 0, 0, a);
  endtask

  task automatic start();
    bit a;
    step(0, 8'h00, 1, 0, a);
  endtask

  task automatic finish_frame();
    bit a;
    while (m_left != 0) idle(1);
    step(0, 8'h00, 0, 1, a);
    idle(1);
  endtask

  function automatic logic [7:0] ref_crc(logic [7:0] q[$]);
    int r = 8'hFF;
    foreach (q[i]) r = ref_byte(r, q[i]);
    return ~r[7:0];
  endfunction

  task automatic rx_frame(logic [7:0] q[$], logic [7:0] c);
    start();
    foreach (q[i]) send(q[i]);
    send(c);
    finish_frame();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] txc;
    bit a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", in_ready, 1);
    chk("R1", crc_out, 8'h00);
    chk("R1", chk_done, 0);
    chk("R1", crc_err | len_err, 0);

    // R2/R4: transmit then receive with own check byte
    q = '{8'h68, 8'h6A, 8'hF1};
    start();
    chk("R3", crc_out, 8'h00);
    foreach (q[i]) send(q[i]);
    while (m_left != 0) idle(1);
    idle(1);
    txc = crc_out;
    chk("R2", txc, ref_crc(q));
    rx_frame(q, txc);
    chk("R4", chk_done, 1);
    chk("R4", crc_err, 0);

    // R5: corrupted check byte, with stalls between bytes
    q = '{8'h3D, 8'h00, 8'hFF, 8'h81};
    start();
    foreach (q[i]) begin send(q[i]); idle(2); end
    send(ref_crc(q) ^ 8'h04);
    finish_frame();
    chk("R5", crc_err, 1);
    idle(1);
    chk("R5", chk_done, 0);

    // R6: only a check byte, and an empty frame
    q = '{};
    rx_frame(q, 8'h00);
    chk("R6", crc_err, 1);
    start();
    finish_frame();
    chk("R6", crc_err, 1);

    // R10: eod while byte in flight is ignored
    start();
    send(8'h55);
    step(0, 8'h00, 0, 1, a);
    idle(1);
    chk("R10", chk_done, 0);

    // R7: abort mid-byte then a clean frame
    start();
    send(8'hA5);
    start();
    chk("R7", chk_done, 0);
    idle(1);
    chk("R7", crc_out, 8'h00);
    q = '{8'h12, 8'h34};
    rx_frame(q, ref_crc(q));
    chk("R7", crc_err, 0);

    // R11: byte with sof not accepted
    step(1, 8'h77, 1, 0, a);
    chk("R11", a, 0);
    idle(1);
    chk("R11", crc_out, 8'h00);

    // R8: 12 bytes OK, 13 bytes too long
    q = '{};
    for (int i = 0; i < 11; i++) q.push_back(8'(i * 37 + 5));
    rx_frame(q, ref_crc(q));
    chk("R8", len_err, 0);
    chk("R8", crc_err, 0);
    q.push_back(8'hC3);
    rx_frame(q, ref_crc(q));
    chk("R8", len_err, 1);
    chk("R8", crc_err, 0);

    idle(3);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule